// File: doc/BRIEF.md
# Interrupt Gate Decode and Stack Select

This block prepares entry into an interrupt handler in 64-bit mode. Given a vector number, the caller's privilege level, the caller's stack pointer and whether the event pushes an error code, the block issues reads over a plain memory request port. It fetches the 16-byte gate descriptor, then the target code-segment descriptor to learn the handler's privilege level, and, when the stack has to move, one stack-pointer slot from the task-state segment. From the gate it assembles the 64-bit handler address and extracts the code selector, the stack-table index and the gate type.

Three stack sources are ranked. A nonzero stack-table index always wins. Otherwise a change of privilege level selects the per-level slot. Otherwise the current stack is kept. The decision to clear the saved stack selector depends only on whether the privilege level changes, and it is made before the stack branch, so it also holds on the stack-table path. The chosen pointer is aligned down to 16 bytes and lowered by the size of the frame the frame builder will write. A one-cycle result strobe hands all of this to the frame builder. The result fields hold until the next result.

Top module: `intgate_stack_sel`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. `busy` rises on the cycle after acceptance and stays high until the result strobe.
- R2: The first memory request has kind code 0 (gate descriptor) and address `idt_base + 16*vector`. The response carries the low 8-byte word in bits 63:0 and the high word in bits 127:64.
- R3: The handler address is {high word bits 31:0, low word bits 63:48, low word bits 15:0}. The code selector is low word bits 31:16. The gate type is low word bits 43:40. The stack-table index is low word bits 34:32.
- R4: The second request has kind code 1 (segment descriptor) and address `(sel[2] ? ldt_base : gdt_base) + (sel & 0xF8)`. The handler privilege level is bits 46:45 of that response.
- R5: A nonzero stack-table index selects stack source code 2. A third request with kind code 2 is then made to `tss_base + 0x1C + 8*index`, and its response bits 63:0 are the raw stack pointer, whatever the privilege levels.
- R6: With a zero index and a handler level different from `req_cpl`, the stack source code is 1 and the third request goes to `tss_base + 4 + 8*level`.
- R7: With a zero index and equal levels, the stack source code is 0, no third request is made, and `req_rsp` is the raw stack pointer.
- R8: `res_zero_ss` is high exactly when the handler level differs from `req_cpl`, on every stack path.
- R9: `res_new_rsp` equals the raw stack pointer with bits 3:0 cleared, minus 40, or minus 48 when the request flagged an error code.
- R10: `res_valid` is high for exactly one cycle per request. The result fields keep their values after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_vector | input | VEC_W | Interrupt vector number |
| req_err_code | input | 1 | Frame includes an error code |
| req_cpl | input | 2 | Current privilege level |
| req_rsp | input | AW | Current stack pointer |
| idt_base | input | AW | Gate table base address |
| gdt_base | input | AW | Global segment table base |
| ldt_base | input | AW | Local segment table base |
| tss_base | input | AW | Task-state segment base |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_kind | output | 2 | 0 gate, 1 segment, 2 stack slot |
| mem_req_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data |
| busy | output | 1 | A request is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_target | output | 64 | Handler address |
| res_cs_sel | output | 16 | Handler code selector |
| res_ist | output | 3 | Stack-table index |
| res_gate_type | output | 4 | Gate type field |
| res_err_code | output | 1 | Error-code flag of the request |
| res_stack_src | output | 2 | 0 current, 1 privilege slot, 2 stack table |
| res_new_rsp | output | AW | Aligned, lowered stack pointer |
| res_zero_ss | output | 1 | Clear the saved stack selector |

## Verification
On every cycle the assertions check the handshake rules, the single-cycle strobe, and that memory requests appear only while busy. At each strobe they also check the ranking rules: a nonzero index implies source 2, source 1 implies a selector clear, and source 0 implies neither an index nor a clear. They also check the low bits of the lowered stack pointer against the frame size. Exact addresses, the bit assembly of the handler address, the per-level and per-index slot offsets, and the clear decision on the stack-table path depend on the descriptor contents. Only the bench's scenarios can show these, by comparing against a memory model.

// File: rtl/intgate_pkg.sv
package intgate_pkg;

   typedef enum logic [1:0] {
      SRC_CUR   = 2'd0,
      SRC_PRIV  = 2'd1,
      SRC_TABLE = 2'd2
   } stk_src_e;

   typedef enum logic [1:0] {
      RD_GATE = 2'd0,
      RD_SEG  = 2'd1,
      RD_SLOT = 2'd2
   } rd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GREQ,
      ST_GWAIT,
      ST_SREQ,
      ST_SWAIT,
      ST_TREQ,
      ST_TWAIT,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic [63:0] target;
      logic [15:0] sel;
      logic [2:0]  ist;
      logic [3:0]  gtype;
   } gate_fields_t;

   localparam int SEG_DPL_LSB = 45;

endpackage

// File: rtl/intgate_field_decode.sv
module intgate_field_decode
   import intgate_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic [127:0]   gate_raw,
   input  logic [AW-1:0]  gdt_base,
   input  logic [AW-1:0]  ldt_base,
   output gate_fields_t   fields,
   output logic [AW-1:0]  seg_addr
);
   localparam logic [15:0] SEL_IDX_MASK = 16'h00F8;
   localparam int          SEL_TI_BIT   = 2;

   logic [63:0] lo_w;
   logic [63:0] hi_w;
   logic [AW-1:0] seg_base;
   logic [15:0] sel_idx;

   assign lo_w = gate_raw[63:0];
   assign hi_w = gate_raw[127:64];

   always_comb begin
      fields.target = {hi_w[31:0], lo_w[63:48], lo_w[15:0]};
      fields.sel    = lo_w[31:16];
      fields.ist    = lo_w[34:32];
      fields.gtype  = lo_w[43:40];
   end

   assign sel_idx  = fields.sel & SEL_IDX_MASK;
   assign seg_base = fields.sel[SEL_TI_BIT] ? ldt_base : gdt_base;
   assign seg_addr = seg_base + AW'(sel_idx);

   logic unused_gate_bits;
   assign unused_gate_bits = ^{lo_w[39:35], lo_w[47:44], hi_w[63:32]};

endmodule

// File: rtl/intgate_stack_choose.sv
module intgate_stack_choose
   import intgate_pkg::*;
#(
   parameter int AW         = 64,
   parameter int IST_BASE   = 28,
   parameter int PRIV_BASE  = 4,
   parameter int SLOT_BYTES = 8
) (
   input  logic [2:0]     ist,
   input  logic [1:0]     tgt_dpl,
   input  logic [1:0]     cur_cpl,
   input  logic [AW-1:0]  tss_base,
   output stk_src_e       src,
   output logic           zero_ss,
   output logic [AW-1:0]  slot_addr
);
   localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);
   localparam bit SLOT_POW2  = ((1 << SLOT_SHIFT) == SLOT_BYTES);

   logic [AW-1:0] ist_off;
   logic [AW-1:0] dpl_off;
   logic          lvl_change;

   generate
      if (SLOT_POW2) begin : g_shift
         assign ist_off = AW'(ist) << SLOT_SHIFT;
         assign dpl_off = AW'(tgt_dpl) << SLOT_SHIFT;
      end else begin : g_mult
         assign ist_off = AW'(ist) * AW'(SLOT_BYTES);
         assign dpl_off = AW'(tgt_dpl) * AW'(SLOT_BYTES);
      end
   endgenerate

   // Level-change decision is taken independently of the stack branch.
   assign lvl_change = (tgt_dpl != cur_cpl);
   assign zero_ss    = lvl_change;

   always_comb begin
      if (ist != 3'd0) begin
         src       = SRC_TABLE;
         slot_addr = tss_base + AW'(IST_BASE) + ist_off;
      end else if (lvl_change) begin
         src       = SRC_PRIV;
         slot_addr = tss_base + AW'(PRIV_BASE) + dpl_off;
      end else begin
         src       = SRC_CUR;
         slot_addr = tss_base;
      end
   end

endmodule

// File: rtl/intgate_frame_align.sv
module intgate_frame_align #(
   parameter int AW          = 64,
   parameter int ALIGN_LSB   = 4,
   parameter int FRAME_BYTES = 40,
   parameter int ERR_BYTES   = 8
) (
   input  logic [AW-1:0] raw_sp,
   input  logic          with_err,
   output logic [AW-1:0] new_sp
);
   localparam logic [AW-1:0] DROP_SHORT = AW'(FRAME_BYTES);
   localparam logic [AW-1:0] DROP_LONG  = AW'(FRAME_BYTES + ERR_BYTES);

   logic [AW-1:0] aligned;

   generate
      if (ALIGN_LSB == 0) begin : g_noalign
         assign aligned = raw_sp;
      end else begin : g_align
         assign aligned = {raw_sp[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
      end
   endgenerate

   assign new_sp = aligned - (with_err ? DROP_LONG : DROP_SHORT);

endmodule

// File: rtl/intgate_stack_sel.sv
module intgate_stack_sel
   import intgate_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int AW          = 64,
   parameter int ALIGN_LSB   = 4,
   parameter int FRAME_BYTES = 40,
   parameter int ERR_BYTES   = 8,
   parameter int IST_BASE    = 28,
   parameter int PRIV_BASE   = 4,
   parameter int SLOT_BYTES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic              req_err_code,
   input  logic [1:0]        req_cpl,
   input  logic [AW-1:0]     req_rsp,
   input  logic [AW-1:0]     idt_base,
   input  logic [AW-1:0]     gdt_base,
   input  logic [AW-1:0]     ldt_base,
   input  logic [AW-1:0]     tss_base,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [1:0]        mem_req_kind,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [127:0]      mem_rsp_data,
   output logic              busy,
   output logic              res_valid,
   output logic [63:0]       res_target,
   output logic [15:0]       res_cs_sel,
   output logic [2:0]        res_ist,
   output logic [3:0]        res_gate_type,
   output logic              res_err_code,
   output logic [1:0]        res_stack_src,
   output logic [AW-1:0]     res_new_rsp,
   output logic              res_zero_ss
);
   localparam int GATE_SHIFT = 4;

   generate
      if (AW < 16) begin : g_bad_aw
         $error("intgate_stack_sel: AW must be at least 16");
      end
      if (VEC_W < 1 || VEC_W + GATE_SHIFT > AW) begin : g_bad_vec
         $error("intgate_stack_sel: VEC_W out of range");
      end
      if (ALIGN_LSB < 0 || ALIGN_LSB >= AW) begin : g_bad_align
         $error("intgate_stack_sel: ALIGN_LSB out of range");
      end
      if (SLOT_BYTES < 1 || FRAME_BYTES < 0 || ERR_BYTES < 0) begin : g_bad_sizes
         $error("intgate_stack_sel: byte counts out of range");
      end
   endgenerate

   seq_state_e    state_q;
   logic          err_q;
   logic [1:0]    cpl_q;
   logic [AW-1:0] sp_q;
   logic [AW-1:0] addr_q;
   rd_kind_e      kind_q;
   gate_fields_t  gate_q;
   stk_src_e      src_q;
   logic          zss_q;

   gate_fields_t  gate_d;
   logic [AW-1:0] seg_addr_d;
   stk_src_e      src_d;
   logic          zss_d;
   logic [AW-1:0] slot_addr_d;
   logic [AW-1:0] new_sp_d;
   logic [1:0]    seg_dpl;

   assign seg_dpl = mem_rsp_data[SEG_DPL_LSB+1:SEG_DPL_LSB];

   intgate_field_decode #(.AW(AW)) u_decode (
      .gate_raw (mem_rsp_data),
      .gdt_base (gdt_base),
      .ldt_base (ldt_base),
      .fields   (gate_d),
      .seg_addr (seg_addr_d)
   );

   intgate_stack_choose #(
      .AW(AW), .IST_BASE(IST_BASE), .PRIV_BASE(PRIV_BASE), .SLOT_BYTES(SLOT_BYTES)
   ) u_choose (
      .ist       (gate_q.ist),
      .tgt_dpl   (seg_dpl),
      .cur_cpl   (cpl_q),
      .tss_base  (tss_base),
      .src       (src_d),
      .zero_ss   (zss_d),
      .slot_addr (slot_addr_d)
   );

   intgate_frame_align #(
      .AW(AW), .ALIGN_LSB(ALIGN_LSB), .FRAME_BYTES(FRAME_BYTES), .ERR_BYTES(ERR_BYTES)
   ) u_frame (
      .raw_sp   (sp_q),
      .with_err (err_q),
      .new_sp   (new_sp_d)
   );

   assign busy          = (state_q != ST_IDLE);
   assign req_ready     = !busy;
   assign mem_req_valid = (state_q == ST_GREQ) || (state_q == ST_SREQ) || (state_q == ST_TREQ);
   assign mem_req_kind  = kind_q;
   assign mem_req_addr  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= 1'b0;
         cpl_q   <= 2'd0;
         sp_q    <= '0;
         addr_q  <= '0;
         kind_q  <= RD_GATE;
         gate_q  <= '0;
         src_q   <= SRC_CUR;
         zss_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  err_q   <= req_err_code;
                  cpl_q   <= req_cpl;
                  sp_q    <= req_rsp;
                  addr_q  <= idt_base + (AW'(req_vector) << GATE_SHIFT);
                  kind_q  <= RD_GATE;
                  state_q <= ST_GREQ;
               end
            end
            ST_GREQ: if (mem_req_ready) state_q <= ST_GWAIT;
            ST_GWAIT: begin
               if (mem_rsp_valid) begin
                  gate_q  <= gate_d;
                  addr_q  <= seg_addr_d;
                  kind_q  <= RD_SEG;
                  state_q <= ST_SREQ;
               end
            end
            ST_SREQ: if (mem_req_ready) state_q <= ST_SWAIT;
            ST_SWAIT: begin
               if (mem_rsp_valid) begin
                  src_q <= src_d;
                  zss_q <= zss_d;
                  if (src_d == SRC_CUR) begin
                     state_q <= ST_DONE;
                  end else begin
                     addr_q  <= slot_addr_d;
                     kind_q  <= RD_SLOT;
                     state_q <= ST_TREQ;
                  end
               end
            end
            ST_TREQ: if (mem_req_ready) state_q <= ST_TWAIT;
            ST_TWAIT: begin
               if (mem_rsp_valid) begin
                  sp_q    <= mem_rsp_data[AW-1:0];
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_target    <= '0;
         res_cs_sel    <= '0;
         res_ist       <= '0;
         res_gate_type <= '0;
         res_err_code  <= 1'b0;
         res_stack_src <= SRC_CUR;
         res_new_rsp   <= '0;
         res_zero_ss   <= 1'b0;
      end else begin
         res_valid <= (state_q == ST_DONE);
         if (state_q == ST_DONE) begin
            res_target    <= gate_q.target;
            res_cs_sel    <= gate_q.sel;
            res_ist       <= gate_q.ist;
            res_gate_type <= gate_q.gtype;
            res_err_code  <= err_q;
            res_stack_src <= src_q;
            res_new_rsp   <= new_sp_d;
            res_zero_ss   <= zss_q;
         end
      end
   end

   logic unused_rsp_bits;
   generate
      if (AW < 128) begin : g_unused_wide
         assign unused_rsp_bits = ^{mem_rsp_data[127:AW], mem_rsp_data[44:0], mem_rsp_data[47]};
      end else begin : g_unused_full
         assign unused_rsp_bits = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/intgate_stack_sel_chk.sv
module intgate_stack_sel_chk #(
   parameter int AW          = 64,
   parameter int ALIGN_LSB   = 4,
   parameter int FRAME_BYTES = 40,
   parameter int ERR_BYTES   = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          busy,
   input logic          mem_req_valid,
   input logic          res_valid,
   input logic [2:0]    res_ist,
   input logic [1:0]    res_stack_src,
   input logic          res_zero_ss,
   input logic          res_err_code,
   input logic [AW-1:0] res_new_rsp
);
   localparam int LB = (ALIGN_LSB == 0) ? 1 : ALIGN_LSB;
   localparam logic [LB-1:0] LOW_SHORT = LB'(0 - FRAME_BYTES);
   localparam logic [LB-1:0] LOW_LONG  = LB'(0 - (FRAME_BYTES + ERR_BYTES));

   a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   a_r2_mem_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);

   a_r5_index_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ist != 3'd0) |-> (res_stack_src == 2'd2));

   a_r7_current_only_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_stack_src == 2'd0) |-> (res_ist == 3'd0 && !res_zero_ss));

   a_r8_priv_slot_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_stack_src == 2'd1) |-> res_zero_ss);

   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   generate
      if (ALIGN_LSB > 0) begin : g_low
         a_r9_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res_new_rsp[LB-1:0] == (res_err_code ? LOW_LONG : LOW_SHORT)));
      end
   endgenerate

endmodule

bind intgate_stack_sel intgate_stack_sel_chk #(
   .AW(AW), .ALIGN_LSB(ALIGN_LSB), .FRAME_BYTES(FRAME_BYTES), .ERR_BYTES(ERR_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .res_valid     (res_valid),
   .res_ist       (res_ist),
   .res_stack_src (res_stack_src),
   .res_zero_ss   (res_zero_ss),
   .res_err_code  (res_err_code),
   .res_new_rsp   (res_new_rsp)
);

// File: tb/intgate_stack_sel_test.sv
`timescale 1ns/1ps
module intgate_stack_sel_test;
   localparam logic [63:0] SLOT_KEY = 64'hC3C3_0000_1234_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [7:0]   req_vector = '0;
   logic         req_err_code = 1'b0;
   logic [1:0]   req_cpl = '0;
   logic [63:0]  req_rsp = '0;
   logic [63:0]  idt_base = 64'h0000_0000_0010_0000;
   logic [63:0]  gdt_base = 64'h0000_0000_0020_0000;
   logic [63:0]  ldt_base = 64'h0000_0000_0030_0000;
   logic [63:0]  tss_base = 64'h0000_0000_0040_0000;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b1;
   logic [1:0]   mem_req_kind;
   logic [63:0]  mem_req_addr;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_data = '0;
   logic         busy, res_valid, res_err_code, res_zero_ss;
   logic [63:0]  res_target, res_new_rsp;
   logic [15:0]  res_cs_sel;
   logic [2:0]   res_ist;
   logic [3:0]   res_gate_type;
   logic [1:0]   res_stack_src;

   intgate_stack_sel uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vector(req_vector), .req_err_code(req_err_code), .req_cpl(req_cpl),
      .req_rsp(req_rsp), .idt_base(idt_base), .gdt_base(gdt_base),
      .ldt_base(ldt_base), .tss_base(tss_base), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_kind(mem_req_kind),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .busy(busy), .res_valid(res_valid),
      .res_target(res_target), .res_cs_sel(res_cs_sel), .res_ist(res_ist),
      .res_gate_type(res_gate_type), .res_err_code(res_err_code),
      .res_stack_src(res_stack_src), .res_new_rsp(res_new_rsp),
      .res_zero_ss(res_zero_ss)
   );

   // Memory model contents and request log
   logic [63:0] m_lo, m_hi;
   logic [1:0]  m_dpl;
   logic [63:0] log_gate_addr, log_seg_addr, log_slot_addr;
   int          slot_reads;

   always @(posedge clk) begin
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         case (mem_req_kind)
            2'd0: begin
               log_gate_addr <= mem_req_addr;
               mem_rsp_data  <= {m_hi, m_lo};
            end
            2'd1: begin
               log_seg_addr <= mem_req_addr;
               mem_rsp_data <= 128'(m_dpl) << 45;
            end
            default: begin
               log_slot_addr <= mem_req_addr;
               slot_reads    <= slot_reads + 1;
               mem_rsp_data  <= {64'hFFFF_FFFF_FFFF_FFFF, mem_req_addr ^ SLOT_KEY};
            end
         endcase
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One scenario: issue a request, wait for the strobe, compare every field.
   task automatic run_case(input string name, input logic [7:0] vec, input logic err,
                           input logic [1:0] cpl, input logic [63:0] rsp,
                           input logic [63:0] lo, input logic [63:0] hi,
                           input logic [1:0] dpl);
      logic [15:0] sel;
      logic [2:0]  idx;
      logic [1:0]  e_src;
      logic        e_zss;
      logic [63:0] e_slot, raw, e_rsp, e_seg;
      int          waited;
      sel = lo[31:16];
      idx = lo[34:32];
      e_zss = (dpl != cpl);
      e_slot = 64'h0;
      if (idx != 3'd0) begin
         e_src = 2'd2; e_slot = tss_base + 64'h1C + 64'(idx) * 8;
      end else if (e_zss) begin
         e_src = 2'd1; e_slot = tss_base + 64'd4 + 64'(dpl) * 8;
      end else begin
         e_src = 2'd0;
      end
      raw   = (e_src == 2'd0) ? rsp : (e_slot ^ SLOT_KEY);
      e_rsp = (raw & ~64'hF) - (err ? 64'd48 : 64'd40);
      e_seg = (sel[2] ? ldt_base : gdt_base) + 64'(sel & 16'h00F8);

      m_lo = lo; m_hi = hi; m_dpl = dpl; slot_reads = 0;
      @(negedge clk);
      chk({name, " R1 ready idle"}, 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vector = vec; req_err_code = err; req_cpl = cpl; req_rsp = rsp;
      @(negedge clk);
      req_valid = 1'b0;
      chk({name, " R1 busy"}, 64'(busy), 64'd1);
      chk({name, " R1 not ready"}, 64'(req_ready), 64'd0);
      waited = 0;
      while (!res_valid && waited < 50) begin
         @(negedge clk);
         waited++;
      end
      chk({name, " R10 strobe"}, 64'(res_valid), 64'd1);
      chk({name, " R1 idle at strobe"}, 64'(busy), 64'd0);
      chk({name, " R2 gate addr"}, log_gate_addr, idt_base + 64'(vec) * 16);
      chk({name, " R3 target"}, res_target, {hi[31:0], lo[63:48], lo[15:0]});
      chk({name, " R3 selector"}, 64'(res_cs_sel), 64'(sel));
      chk({name, " R3 type"}, 64'(res_gate_type), 64'(lo[43:40]));
      chk({name, " R3 index"}, 64'(res_ist), 64'(idx));
      chk({name, " R4 seg addr"}, log_seg_addr, e_seg);
      if (e_src == 2'd2) chk({name, " R5 source"}, 64'(res_stack_src), 64'(e_src));
      else if (e_src == 2'd1) chk({name, " R6 source"}, 64'(res_stack_src), 64'(e_src));
      else chk({name, " R7 source"}, 64'(res_stack_src), 64'(e_src));
      if (e_src != 2'd0) begin
         chk({name, " R5 R6 slot addr"}, log_slot_addr, e_slot);
         chk({name, " R5 R6 slot reads"}, 64'(slot_reads), 64'd1);
      end else begin
         chk({name, " R7 no slot read"}, 64'(slot_reads), 64'd0);
      end
      chk({name, " R8 zero ss"}, 64'(res_zero_ss), 64'(e_zss));
      chk({name, " R9 new rsp"}, res_new_rsp, e_rsp);
      chk({name, " R9 err flag"}, 64'(res_err_code), 64'(err));
      @(negedge clk);
      chk({name, " R10 strobe falls"}, 64'(res_valid), 64'd0);
      chk({name, " R10 hold"}, res_new_rsp, e_rsp);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset ready", 64'(req_ready), 64'd1);
      chk("R1 reset busy", 64'(busy), 64'd0);
      chk("R10 reset strobe", 64'(res_valid), 64'd0);
      chk("R2 reset mem idle", 64'(mem_req_valid), 64'd0);
   endtask

   // lo layout: [63:48] off mid, [43:40] type, [34:32] index, [31:16] sel, [15:0] off low
   task automatic t_table_with_change;   // R5 R8: index 3, level 3 -> 0
      run_case("table+chg", 8'h0E, 1'b1, 2'd3, 64'h7FFF_0000_1234_5679,
               64'hABCD_8E00_0000_0008 | (64'd3 << 32) | 64'h1111, 64'h0000_0000_FFFF_8000, 2'd0);
   endtask
   task automatic t_table_same;          // R5 R8: index 7, same level
      run_case("table same", 8'hFF, 1'b0, 2'd0, 64'h0000_0000_0000_0FFF,
               64'h1234_8F00_0010_BEEF | (64'd7 << 32), 64'h89AB_CDEF, 2'd0);
   endtask
   task automatic t_priv;                // R6: level 3 -> 1, local table selector
      run_case("priv", 8'h21, 1'b0, 2'd3, 64'h0000_7000_0000_0123,
               64'h5555_8E00_002C_4444, 64'h0000_0001, 2'd1);
   endtask
   task automatic t_priv_err;            // R6 R9 with error code, level 2 -> 0
      run_case("priv err", 8'h0D, 1'b1, 2'd2, 64'h0,
               64'hFFFF_8E00_0010_0000, 64'hFFFF_FFFF, 2'd0);
   endtask
   task automatic t_current;             // R7: no switch
      run_case("current", 8'h80, 1'b0, 2'd0, 64'h0000_1000_0000_2037,
               64'h0001_8F00_0008_0002, 64'h0, 2'd0);
   endtask
   task automatic t_current_err;         // R7 R9: error code, already aligned pointer
      run_case("current err", 8'h03, 1'b1, 2'd1, 64'h0000_0000_0000_1000,
               64'h9999_8E00_00FF_7777, 64'h1357_9BDF, 2'd1);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_table_with_change();
      t_table_same();
      t_priv();
      t_priv_err();
      t_current();
      t_current_err();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule